// File: doc/BRIEF.md
# Ping-Pong One-Shot DMA Channel

A single DMA channel that owns two descriptor slots and moves between them, one after the other. Each slot holds a start address, a byte length and a command word. At any time one slot is the active one and the other is idle. Software programs and arms the idle slot while the active slot is moving data. When the active transfer finishes, the channel marks that slot done and makes the other slot active. If the other slot is already armed, its first memory request is issued in the cycle right after the last beat of the previous transfer, so there is no gap between transfers.

The transfers go out over a simple request/grant memory port that is one data word wide. The address steps up by the word size on every accepted beat, and the remaining length steps down by the same amount. Each slot has a sticky done flag, and the OR of the two flags drives a completion output. A control register reports which slot is active, the two done flags and a busy indication. Writing to the control register clears done flags. A full subsystem places several identical copies of this block side by side.

Top module: `dma_pp_channel`

## Requirements
- R1: After reset, slot 0 is active, both slots are disarmed, all slot address, length and command registers read zero, both done flags are clear, and `mem_req` and `done_irq` are low.
- R2: With `reg_ctl_sel` low, `reg_off` selects a descriptor register. Bit 4 selects the slot (0 or 1). Bits 3:2 select the register: 0 is the address, 1 is the length and 2 is the command word. Bits 3:2 equal to 3 read as zero. A read returns the live value of the selected register, zero-extended to 32 bits, and a write stores the low bits of `reg_wdata`.
- R3: Command bit 0 is the arm bit. Writing a command word with bit 0 set arms the slot. A read of the command register returns the stored upper bits with bit 0 showing the present armed state. `mem_req` is high only while the active slot is armed and its remaining length is at least one word (DATA_W/8 bytes).
- R4: Each accepted beat, meaning `mem_req` and `mem_gnt` both high at a clock edge, adds DATA_W/8 to the active slot's address and subtracts DATA_W/8 from its length. While a request is not granted, `mem_req` stays high and `mem_addr` does not change.
- R5: A transfer ends when the beat accepted has a remaining length of less than two words, so the transfer makes floor(length / word size) beats. An armed active slot whose length is below one word finishes in one cycle without raising `mem_req`.
- R6: When a transfer ends, that slot is disarmed, its done flag is set and the other slot becomes active. If the other slot is armed, `mem_req` for its start address is high in the very next cycle.
- R7: If the newly active slot is not armed, `mem_req` stays low until software arms that slot. Re-arming the slot that just finished does not restart the channel.
- R8: Writes to any descriptor register of an armed slot are ignored.
- R9: A control register read (`reg_ctl_sel` high) returns: bit 0 the active slot, bit 1 the slot 0 done flag, bit 2 the slot 1 done flag, and bit 3 busy (the active slot is armed). All other bits read zero. A control write with bit 1 or bit 2 set clears the matching done flag.
- R10: `done_irq` is high exactly when at least one done flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_ctl_sel | input | 1 | Selects the control register instead of the descriptor window |
| reg_off | input | 5 | Descriptor window byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory beat request |
| mem_addr | output | ADDR_W | Byte address of the requested beat |
| mem_gnt | input | 1 | Memory accepts the beat in this cycle |
| done_irq | output | 1 | At least one slot has a done flag set |

## Verification
The bench builds the block with its default parameters: a 32-bit data word (4-byte beats), 32-bit addresses and a 16-bit length field. The 16-bit length makes the truncation of wide register writes visible. The 4-byte beat puts the "last beat" threshold at 8 bytes and the "no beat at all" threshold at 4 bytes, so short lengths such as 3, 4, 8 and 12 bytes cover each side of both edges. Holding the grant low and then raising it shows that the request is held without change, and that the switch from one slot to the other happens with no idle cycle.

// File: rtl/dma_pp_pkg.sv
package dma_pp_pkg;
   localparam int REG_W       = 32;
   localparam int NSLOT       = 2;
   localparam int OFF_W       = 5;
   localparam int SLOT_BIT    = 4;
   localparam int ARM_BIT     = 0;
   localparam int CTL_ACT     = 0;
   localparam int CTL_DONE_LO = 1;
   localparam int CTL_BUSY    = 3;

   typedef enum logic [1:0] {
      RSEL_ADDR = 2'd0,
      RSEL_LEN  = 2'd1,
      RSEL_CMD  = 2'd2,
      RSEL_NONE = 2'd3
   } rsel_e;
endpackage

// File: rtl/dma_pp_slot.sv
module dma_pp_slot
   import dma_pp_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int WORD_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  rsel_e             wr_sel,
   input  logic [REG_W-1:0]  wdata,
   input  logic              beat,
   input  logic              finish,
   output logic [ADDR_W-1:0] addr,
   output logic [LEN_W-1:0]  len,
   output logic [REG_W-1:0]  cmd,
   output logic              armed
);
   localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);
   localparam logic [LEN_W-1:0]  LEN_STEP  = LEN_W'(WORD_BYTES);

   logic [REG_W-1:0] cmd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr  <= '0;
         len   <= '0;
         cmd_q <= '0;
         armed <= 1'b0;
      end else begin
         if (wr_en && !armed) begin
            case (wr_sel)
               RSEL_ADDR: addr <= wdata[ADDR_W-1:0];
               RSEL_LEN:  len  <= wdata[LEN_W-1:0];
               RSEL_CMD: begin
                  cmd_q <= wdata;
                  armed <= wdata[ARM_BIT];
               end
               default: ;
            endcase
         end
         if (beat) begin
            addr <= addr + ADDR_STEP;
            len  <= len - LEN_STEP;
         end
         if (finish) armed <= 1'b0;
      end
   end

   always_comb begin
      cmd          = cmd_q;
      cmd[ARM_BIT] = armed;
   end

   // R8: an armed slot keeps its address against software writes
   a_r8_locked_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && wr_en && !beat) |=> $stable(addr));
   // R4: every beat takes one word off the length
   a_r4_len_step: assert property (@(posedge clk) disable iff (!rst_n)
      beat |=> (len == $past(len) - LEN_STEP));
   // R6: a finished slot is disarmed
   a_r6_disarm: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> !armed);
endmodule

// File: rtl/dma_pp_seq.sv
module dma_pp_seq
   import dma_pp_pkg::*;
#(
   parameter int LEN_W      = 16,
   parameter int WORD_BYTES = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NSLOT-1:0]            armed,
   input  logic [NSLOT-1:0][LEN_W-1:0] lens,
   input  logic                        mem_gnt,
   input  logic [NSLOT-1:0]            clr_done,
   output logic                        act,
   output logic                        mem_req,
   output logic [NSLOT-1:0]            beat,
   output logic [NSLOT-1:0]            finish,
   output logic [NSLOT-1:0]            done
);
   localparam logic [LEN_W-1:0] ONE_WORD = LEN_W'(WORD_BYTES);
   localparam logic [LEN_W-1:0] TWO_WORD = LEN_W'(2 * WORD_BYTES);

   logic [LEN_W-1:0] cur_len;
   logic             cur_armed, has_beat, last_beat, accept, fin;

   always_comb begin
      cur_len   = lens[act];
      cur_armed = armed[act];
      has_beat  = (cur_len >= ONE_WORD);
      last_beat = (cur_len <  TWO_WORD);
      mem_req   = cur_armed && has_beat;
      accept    = mem_req && mem_gnt;
      fin       = cur_armed && (!has_beat || (accept && last_beat));
      beat      = '0;
      finish    = '0;
      beat[act]   = accept;
      finish[act] = fin;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act  <= 1'b0;
         done <= '0;
      end else begin
         if (fin) act <= ~act;
         done <= (done & ~clr_done) | finish;
      end
   end

   // R6: completion hands over to the other slot
   a_r6_flip: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> (act != $past(act)));
   // R6: completion leaves the finished slot's done flag set
   a_r6_done_set: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> done[$past(act)]);
   // R4: an ungranted request persists on the same slot
   a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(act)));
endmodule

// File: rtl/dma_pp_regif.sv
module dma_pp_regif
   import dma_pp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic                         reg_we,
   input  logic                         reg_ctl_sel,
   input  logic [OFF_W-1:0]             reg_off,
   input  logic [REG_W-1:0]             reg_wdata,
   input  logic [NSLOT-1:0][ADDR_W-1:0] slot_addr,
   input  logic [NSLOT-1:0][LEN_W-1:0]  slot_len,
   input  logic [NSLOT-1:0][REG_W-1:0]  slot_cmd,
   input  logic                         act,
   input  logic                         busy,
   input  logic [NSLOT-1:0]             done,
   output logic [NSLOT-1:0]             slot_wr,
   output rsel_e                        wr_sel,
   output logic [NSLOT-1:0]             clr_done,
   output logic [REG_W-1:0]             reg_rdata
);
   logic sel_slot;

   always_comb begin
      sel_slot = reg_off[SLOT_BIT];
      wr_sel   = rsel_e'(reg_off[3:2]);
      slot_wr  = '0;
      clr_done = '0;
      if (reg_we && !reg_ctl_sel) slot_wr[sel_slot] = 1'b1;
      if (reg_we &&  reg_ctl_sel) clr_done = reg_wdata[CTL_DONE_LO +: NSLOT];

      reg_rdata = '0;
      if (reg_ctl_sel) begin
         reg_rdata[CTL_ACT]                  = act;
         reg_rdata[CTL_DONE_LO +: NSLOT]     = done;
         reg_rdata[CTL_BUSY]                 = busy;
      end else begin
         case (wr_sel)
            RSEL_ADDR: reg_rdata = REG_W'(slot_addr[sel_slot]);
            RSEL_LEN:  reg_rdata = REG_W'(slot_len[sel_slot]);
            RSEL_CMD:  reg_rdata = slot_cmd[sel_slot];
            default:   reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/dma_pp_channel.sv
module dma_pp_channel
   import dma_pp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_ctl_sel,
   input  logic [4:0]        reg_off,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_gnt,
   output logic              done_irq
);
   localparam int WORD_BYTES = DATA_W / 8;
   localparam int WB_LG      = $clog2(WORD_BYTES);

   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0)
      $error("DATA_W must be a power of two of at least 8");
   if (ADDR_W < 8 || ADDR_W > REG_W)
      $error("ADDR_W must lie between 8 and the register width");
   if (LEN_W < WB_LG + 2 || LEN_W > REG_W)
      $error("LEN_W must hold two words and fit a register");

   logic [NSLOT-1:0][ADDR_W-1:0] slot_addr;
   logic [NSLOT-1:0][LEN_W-1:0]  slot_len;
   logic [NSLOT-1:0][REG_W-1:0]  slot_cmd;
   logic [NSLOT-1:0]             armed, beat, finish, done, slot_wr, clr_done;
   logic                         act;
   rsel_e                        wr_sel;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      dma_pp_slot #(
         .ADDR_W     (ADDR_W),
         .LEN_W      (LEN_W),
         .WORD_BYTES (WORD_BYTES)
      ) u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (slot_wr[s]),
         .wr_sel (wr_sel),
         .wdata  (reg_wdata),
         .beat   (beat[s]),
         .finish (finish[s]),
         .addr   (slot_addr[s]),
         .len    (slot_len[s]),
         .cmd    (slot_cmd[s]),
         .armed  (armed[s])
      );
   end

   dma_pp_seq #(
      .LEN_W      (LEN_W),
      .WORD_BYTES (WORD_BYTES)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .armed    (armed),
      .lens     (slot_len),
      .mem_gnt  (mem_gnt),
      .clr_done (clr_done),
      .act      (act),
      .mem_req  (mem_req),
      .beat     (beat),
      .finish   (finish),
      .done     (done)
   );

   dma_pp_regif #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W)
   ) u_regif (
      .reg_we      (reg_we),
      .reg_ctl_sel (reg_ctl_sel),
      .reg_off     (reg_off),
      .reg_wdata   (reg_wdata),
      .slot_addr   (slot_addr),
      .slot_len    (slot_len),
      .slot_cmd    (slot_cmd),
      .act         (act),
      .busy        (armed[act]),
      .done        (done),
      .slot_wr     (slot_wr),
      .wr_sel      (wr_sel),
      .clr_done    (clr_done),
      .reg_rdata   (reg_rdata)
   );

   assign mem_addr = slot_addr[act];
   assign done_irq = |done;

   // R4: the beat address holds while the memory stalls
   a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> $stable(mem_addr));
   // R10: completion output follows the done flags after a finish
   a_r10_irq_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
      (|finish) |=> done_irq);
endmodule

// File: tb/dma_pp_channel_tb.sv
module dma_pp_channel_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 5000;
   localparam int NVEC       = 6;

   localparam logic [4:0]  V_OFF [NVEC] = '{5'h10, 5'h14, 5'h18, 5'h00, 5'h04, 5'h08};
   localparam logic [31:0] V_WR  [NVEC] = '{32'hDEAD_BEE0, 32'h0000_0040, 32'hA5A5_0000,
                                            32'h0000_1234, 32'h0001_FFFF, 32'h0000_00F0};
   localparam logic [31:0] V_EXP [NVEC] = '{32'hDEAD_BEE0, 32'h0000_0040, 32'hA5A5_0000,
                                            32'h0000_1234, 32'h0000_FFFF, 32'h0000_00F0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic        reg_ctl_sel = 1'b0;
   logic [4:0]  reg_off = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_gnt = 1'b0;
   logic        done_irq;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dma_pp_channel dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ctl_sel(reg_ctl_sel),
      .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .done_irq(done_irq)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic ctl, input logic [4:0] off, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_ctl_sel = ctl; reg_off = off; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic ctl, input logic [4:0] off, output logic [31:0] d);
      reg_ctl_sel = ctl; reg_off = off;
      #1;
      d = reg_rdata;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(1'b1, 5'h00, v); check("R1 ctl", v, 32'h0);
      rd(1'b0, 5'h00, v); check("R1 slot0 addr", v, 32'h0);
      rd(1'b0, 5'h18, v); check("R1 slot1 cmd", v, 32'h0);
      check("R1 mem_req", 32'(mem_req), 32'h0);
      check("R1 done_irq", 32'(done_irq), 32'h0);

      // R2 register map walk
      for (int i = 0; i < NVEC; i++) begin
         wr(1'b0, V_OFF[i], V_WR[i]);
         rd(1'b0, V_OFF[i], v);
         check("R2 readback", v, V_EXP[i]);
      end
      rd(1'b0, 5'h0C, v); check("R2 hole slot0", v, 32'h0);
      rd(1'b0, 5'h1C, v); check("R2 hole slot1", v, 32'h0);

      // R3 / R4 / R5: slot 0, 12 bytes, stalled then granted
      wr(1'b0, 5'h00, 32'h1000);
      wr(1'b0, 5'h04, 32'd12);
      wr(1'b0, 5'h08, 32'h1);
      check("R3 req after arm", 32'(mem_req), 32'h1);
      check("R3 first addr", mem_addr, 32'h1000);
      repeat (2) @(negedge clk);
      check("R4 req held", 32'(mem_req), 32'h1);
      check("R4 addr held", mem_addr, 32'h1000);
      mem_gnt = 1'b1;
      @(negedge clk);
      check("R4 addr step", mem_addr, 32'h1004);
      rd(1'b0, 5'h04, v); check("R4 len step", v, 32'd8);
      @(negedge clk);
      check("R4 addr step 2", mem_addr, 32'h1008);
      @(negedge clk);
      check("R5 ended after three beats", 32'(mem_req), 32'h0);
      rd(1'b1, 5'h00, v); check("R6 R9 ctl after slot0", v, 32'h3);
      check("R10 irq set", 32'(done_irq), 32'h1);
      rd(1'b0, 5'h08, v); check("R6 slot0 disarmed", v, 32'h0);
      rd(1'b0, 5'h00, v); check("R4 final addr", v, 32'h100C);

      // R7: idle slot unarmed, re-arming finished slot does not restart
      repeat (3) @(negedge clk);
      check("R7 stays idle", 32'(mem_req), 32'h0);
      wr(1'b0, 5'h04, 32'd8);
      wr(1'b0, 5'h08, 32'h1);
      check("R7 no restart", 32'(mem_req), 32'h0);
      rd(1'b1, 5'h00, v); check("R7 ctl", v, 32'h3);

      // R9 / R10: clear done flag of slot 0
      wr(1'b1, 5'h00, 32'h2);
      rd(1'b1, 5'h00, v); check("R9 clear done0", v, 32'h1);
      check("R10 irq cleared", 32'(done_irq), 32'h0);

      // R6 / R8: slot1 runs then slot0 follows with no gap
      mem_gnt = 1'b0;
      wr(1'b0, 5'h10, 32'h2000);
      wr(1'b0, 5'h14, 32'd4);
      wr(1'b0, 5'h18, 32'h1);
      check("R3 slot1 req", 32'(mem_req), 32'h1);
      check("R3 slot1 addr", mem_addr, 32'h2000);
      rd(1'b1, 5'h00, v); check("R9 busy", v, 32'h9);
      wr(1'b0, 5'h10, 32'h5555);
      rd(1'b0, 5'h10, v); check("R8 armed write ignored", v, 32'h2000);
      mem_gnt = 1'b1;
      @(negedge clk);
      check("R6 no gap req", 32'(mem_req), 32'h1);
      check("R6 no gap addr", mem_addr, 32'h100C);
      rd(1'b1, 5'h00, v); check("R9 ctl handover", v, 32'hC);
      @(negedge clk);
      check("R4 slot0 step", mem_addr, 32'h1010);
      @(negedge clk);
      check("R5 slot0 ended", 32'(mem_req), 32'h0);
      rd(1'b1, 5'h00, v); check("R9 both done", v, 32'h7);

      // R5: sub-word length finishes without a request
      wr(1'b1, 5'h00, 32'h6);
      rd(1'b1, 5'h00, v); check("R9 clear both", v, 32'h1);
      mem_gnt = 1'b0;
      wr(1'b0, 5'h14, 32'd3);
      wr(1'b0, 5'h18, 32'h1);
      check("R5 no request short", 32'(mem_req), 32'h0);
      @(negedge clk);
      rd(1'b1, 5'h00, v); check("R5 short finished", v, 32'h4);
      rd(1'b0, 5'h10, v); check("R5 addr untouched", v, 32'h2004);
      check("R10 irq short", 32'(done_irq), 32'h1);

      summary();
      $finish;
   end
endmodule